// File: doc/BRIEF.md
# Flash Query Mode Controller

This block tracks whether a flash device's command interface is in query mode. It watches the write strobes on the word-addressed bus. When a correct query command arrives, it switches from array reads to a fixed identification table. That table identifies the device and its primary command set. Once in query mode, the block stays there until software writes the reset command, and then it goes back to array reads.

Two device states gate entry. A ready flag reports that the device can read array data. An autoselect flag reports that the device is in its identifier mode. A query command is accepted in either of these states. While a program or erase operation is busy outside autoselect, the command is ignored. The `query_mode` output tells the surrounding read path whether to use `rd_data` or the array data. When that output is low, this block drives zero.

Top module: `flash_query_ctrl`

## Requirements
- R1: After reset, `query_mode` is 0 and `rd_data` is 0000h.
- R2: A write of data 0098h to word address 55h while `ready` is 1 sets `query_mode` on the next clock edge.
- R3: A write of 0098h to address 55h while `autosel` is 1 enters query mode even if `ready` is 0.
- R4: Outside query mode, the following writes leave `query_mode` at 0: a write of 0098h to any address other than 55h, any other data value, or a query command while both `ready` and `autosel` are 0.
- R5: In query mode, only a write of data 00F0h to any address clears `query_mode`. All other writes, including a repeated 0098h, leave it set.
- R6: After the reset command, the block reports array mode (`query_mode` = 0), even if query mode was entered from autoselect and `autosel` is still 1.
- R7: `rd_data` takes its new value on the clock edge that samples `rd_en`, and it holds that value while `rd_en` is 0.
- R8: In query mode, reads of addresses 10h, 11h and 12h return 0051h, 0052h and 0059h ("QRY").
- R9: In query mode, address 13h returns 0002h, address 15h returns 0040h, and addresses 14h and 16h return 0000h.
- R10: In query mode, addresses 17h to 1Ah return 0000h, and so does every address outside 10h to 1Ah.
- R11: A read sampled while `query_mode` is 0 returns 0000h.
- R12: A read uses the mode in force before the edge that samples it. A write in the same cycle affects only later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Qualified bus write strobe, one cycle per write |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Write data (command word) |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Word address of the read |
| ready | input | 1 | Device ready to read array data |
| autosel | input | 1 | Device is in autoselect mode |
| rd_data | output | DW | Query table data for the last read |
| query_mode | output | 1 | 1 selects query data, 0 selects array data |

## Verification
The bench aims query commands at the wrong address and at the right address with the wrong data. A design that decodes only one of the two fields would enter query mode on these writes. It sends the command while busy, with and without autoselect. A design that ignores either flag would enter when it should not, or miss a valid entry. It sends reset commands outside query mode and repeated query commands inside it. A design that toggles the mode on these writes would leave query mode without a reset. Reads issued in the same cycle as an entering or exiting write check which mode the read uses. Reads of table addresses that border the implemented range, and of aliases with upper address bits set, catch a loose address decode.

// File: rtl/flash_query_ctrl.sv
module flash_query_ctrl #(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          ready,
  input  logic          autosel,
  output logic [DW-1:0] rd_data,
  output logic          query_mode
);

  localparam logic [AW-1:0] CMD_ADDR = AW'(8'h55);
  localparam logic [DW-1:0] CMD_QRY  = DW'(8'h98);
  localparam logic [DW-1:0] CMD_EXIT = DW'(8'hF0);

  logic q;
  logic go_query, go_array;

  assign go_query = wr_en && !q && wr_data == CMD_QRY && wr_addr == CMD_ADDR
                    && (ready || autosel);
  assign go_array = wr_en && q && wr_data == CMD_EXIT;

  always_ff @(posedge clk) begin
    if (!rst_n)        q <= 1'b0;
    else if (go_query) q <= 1'b1;
    else if (go_array) q <= 1'b0;
  end

  function automatic logic [DW-1:0] id_word(input logic [AW-1:0] a);
    case (a)
      AW'(8'h10): id_word = DW'(8'h51);
      AW'(8'h11): id_word = DW'(8'h52);
      AW'(8'h12): id_word = DW'(8'h59);
      AW'(8'h13): id_word = DW'(8'h02);
      AW'(8'h15): id_word = DW'(8'h40);
      default:    id_word = '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= q ? id_word(rd_addr) : '0;
  end

  assign query_mode = q;

  AST_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !query_mode && wr_data == CMD_QRY && wr_addr == CMD_ADDR && (ready || autosel))
    |=> query_mode); // R2
  AST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && query_mode && wr_data == CMD_EXIT) |=> !query_mode); // R5
  AST_HOLD_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
    (query_mode && !(wr_en && wr_data == CMD_EXIT)) |=> query_mode); // R5
  AST_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!query_mode && !(wr_en && wr_data == CMD_QRY && wr_addr == CMD_ADDR && (ready || autosel)))
    |=> !query_mode); // R4
  AST_ARRAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !query_mode) |=> rd_data == '0); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R7

endmodule

// File: tb/flash_query_ctrl_bench.sv
module flash_query_ctrl_bench;
  localparam int AW = 22;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, ready = 1, autosel = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic query_mode;

  int checks = 0, errors = 0;
  logic m_q = 0;
  logic [DW-1:0] m_rd = '0;

  always #10 clk = ~clk;

  flash_query_ctrl #(.AW(AW), .DW(DW)) u_flash_query_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .ready(ready), .autosel(autosel),
    .rd_data(rd_data), .query_mode(query_mode));

  function automatic logic [DW-1:0] ref_word(input logic [AW-1:0] a);
    if (a == 'h10) return 16'h0051;
    if (a == 'h11) return 16'h0052;
    if (a == 'h12) return 16'h0059;
    if (a == 'h13) return 16'h0002;
    if (a == 'h15) return 16'h0040;
    return 16'h0000;
  endfunction

  function automatic string rd_tag(input logic q, input logic [AW-1:0] a);
    if (!q) return "R11";
    if (a >= 'h10 && a <= 'h12) return "R8";
    if (a >= 'h13 && a <= 'h16) return "R9";
    return "R10";
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input logic re, input logic [AW-1:0] ra,
                      input logic rdy, input logic asel, input string mtag);
    logic nq;
    string rt;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    ready = rdy; autosel = asel;
    nq = m_q;
    if (we && !m_q && wd == 16'h0098 && wa == 'h55 && (rdy || asel)) nq = 1;
    else if (we && m_q && wd == 16'h00F0) nq = 0;
    rt = re ? rd_tag(m_q, ra) : "R7";
    if (re) m_rd = m_q ? ref_word(ra) : 16'h0;
    m_q = nq;
    @(negedge clk);
    chk(mtag, {15'b0, query_mode}, {15'b0, m_q});
    chk(rt, rd_data, m_rd);
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", {15'b0, query_mode}, 16'h0);
    chk("R1", rd_data, 16'h0);
    rst_n = 1;
    step(0, 0, 0, 1, 'h10, 1, 0, "R11");
    step(1, 'h56, 16'h0098, 0, 0, 1, 0, "R4");
    step(1, 'h55, 16'h0090, 0, 0, 1, 0, "R4");
    step(1, 'h55, 16'h0098, 0, 0, 0, 0, "R4");
    step(1, 'h55, 16'h00F0, 1, 'h10, 1, 0, "R4");
    step(1, 'h55, 16'h0098, 1, 'h10, 1, 0, "R2 R12");
    for (int a = 'h0F; a <= 'h1B; a++) step(0, 0, 0, 1, AW'(a), 1, 0, "R5");
    step(0, 0, 0, 1, 'h10010, 1, 0, "R10");
    step(0, 0, 0, 0, 0, 1, 0, "R7");
    step(1, 'h55, 16'h0098, 0, 0, 1, 0, "R5");
    step(1, 'h123, 16'h00F0, 1, 'h11, 1, 0, "R5 R12");
    step(0, 0, 0, 1, 'h11, 1, 0, "R11");
    step(1, 'h55, 16'h0098, 0, 0, 0, 1, "R3");
    step(0, 0, 0, 1, 'h12, 0, 1, "R3");
    step(1, 'h0, 16'h00F0, 0, 0, 0, 1, "R6");
    step(0, 0, 0, 1, 'h12, 0, 1, "R6");
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] wa, ra;
      logic [DW-1:0] wd;
      int r = $urandom_range(0, 9);
      wa = (r < 6) ? AW'('h55) : AW'($urandom_range(0, 'hFF));
      r = $urandom_range(0, 9);
      wd = (r < 4) ? 16'h0098 : (r < 6) ? 16'h00F0 : 16'($urandom);
      ra = ($urandom_range(0, 3) != 0) ? AW'($urandom_range('h0E, 'h1C)) : AW'($urandom);
      step($urandom_range(0, 2) == 0, wa, wd, $urandom_range(0, 1) == 1, ra,
           $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, "R5");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule